// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches sixteen general-purpose input pins, split into two groups of eight. Each pin can be unmasked on its own. When any unmasked pin in a group moves from low to high or from high to low, that group's flag is set. The flag stays set until software clears it, either by writing a one to the flag bit or by pulsing the group's acknowledge input when the interrupt is serviced. Each pin passes through a two-flop synchroniser before edge detection, so the pins may be asynchronous to the block clock.

Each group drives its own interrupt request line. A request is raised only while the group's flag is set, the group's enable bit is set and the global interrupt enable input is high. A small register bus gives access to the flags, the two mask registers and the enable register. A read has no side effects.

Top module: `pin_change_irq`

## Requirements
- R1: Pins 0..7 belong to group 0 and set flag bit 0 (read at offset 0). Pins 8..15 belong to group 1 and set flag bit 1.
- R2: A rising edge or a falling edge on a pin whose mask bit is 1 sets its group's flag. The flag stays set after the pin goes quiet.
- R3: A pin whose mask bit is 0 never sets a flag. Group 0 mask is at offset 1, and its bit i enables pin i. Group 1 mask is at offset 2, and its bit i enables pin 8+i.
- R4: A bus write to offset 0 clears each flag whose data bit (bit 0 for group 0, bit 1 for group 1) is 1. A flag whose data bit is 0 is left unchanged.
- R5: A one-cycle pulse on ack_i[g] clears flag g and leaves the other flag unchanged.
- R6: If a qualifying pin change reaches the flag in the same cycle as a write-one clear or an acknowledge for that group, the flag ends up set.
- R7: irq_o[g] is a registered output that goes high one cycle after flag g, enable bit g (offset 3, bit g) and gie_i are all high. It drops one cycle after any of the three goes low.
- R8: Bits 7..2 of the flag register and of the enable register always read as zero, and writes to them have no effect.
- R9: After reset, all flags, masks, enables, irq_o and the read data are zero.
- R10: Read data is registered. bus_rdata shows the register selected by bus_addr one cycle after the address is applied, and a read does not change any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 16 | Asynchronous input pins (group 0 = bits 7..0) |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 2 | Per-group interrupt acknowledge pulse |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 2 | Per-group interrupt request |

## Verification
The flag function is driven with a rising edge and a falling edge on one pin of each group. This shows that both edge directions are detected and that a pin is routed to the right group. Changes on masked-off pins, including pins in the other group, confirm that the mask gates detection per pin. Clears are tried three ways: a write with mixed one and zero data bits, an acknowledge with no pending change, and an acknowledge or write that lands in the same cycle as a new change. Together these separate a true write-one-clear from a plain write, and show that a clear can never discard a set.

// File: rtl/pin_change_irq_pkg.sv
package pin_change_irq_pkg;
  localparam int unsigned GROUPS_DEF  = 2;
  localparam int unsigned PINS_DEF    = 8;
  localparam int unsigned DATA_W_DEF  = 8;
  // offset 0 holds the flags, masks follow one per group, enables come last
  localparam int unsigned OFS_FLAGS     = 0;
  localparam int unsigned OFS_MASK_BASE = 1;

  function automatic int unsigned ofs_enable(input int unsigned groups);
    return OFS_MASK_BASE + groups;
  endfunction
endpackage

// File: rtl/pci_sync.sv
module pci_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pci_edge.sv
module pci_edge #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] mask,
  output logic             hit
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  assign hit = |((level ^ prev_q) & mask);
endmodule

// File: rtl/pci_flag.sv
module pci_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !flag); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!clr && !hit) |=> $stable(flag)); // R2
endmodule

// File: rtl/pci_regs.sv
module pci_regs
  import pin_change_irq_pkg::*;
#(
  parameter int unsigned GROUPS = GROUPS_DEF,
  parameter int unsigned PINS   = PINS_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned ADDR_W = $clog2(GROUPS + 2)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_we,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic [GROUPS-1:0]            flags,
  output logic [GROUPS-1:0][PINS-1:0]  mask,
  output logic [GROUPS-1:0]            enable,
  output logic [GROUPS-1:0]            w1c
);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(OFS_FLAGS);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(ofs_enable(GROUPS));

  logic [DATA_W-1:0] rd_mux;

  assign w1c = (bus_we && bus_addr == A_FLAGS) ? bus_wdata[GROUPS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask   <= '0;
      enable <= '0;
    end else if (bus_we) begin
      for (int g = 0; g < GROUPS; g++) begin
        if (bus_addr == ADDR_W'(OFS_MASK_BASE + g)) mask[g] <= bus_wdata[PINS-1:0];
      end
      if (bus_addr == A_EN) enable <= bus_wdata[GROUPS-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_FLAGS) rd_mux[GROUPS-1:0] = flags;
    if (bus_addr == A_EN)    rd_mux[GROUPS-1:0] = enable;
    for (int g = 0; g < GROUPS; g++) begin
      if (bus_addr == ADDR_W'(OFS_MASK_BASE + g)) rd_mux[PINS-1:0] = mask[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  AST_UNUSED_FLAG_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == A_FLAGS) |-> (bus_rdata[DATA_W-1:GROUPS] == '0)); // R8
  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> ($stable(mask) && $stable(enable))); // R10
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pin_change_irq_pkg::*;
#(
  parameter int unsigned GROUPS   = GROUPS_DEF,
  parameter int unsigned PINS     = PINS_DEF,
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned SYNC_LEN = 2,
  localparam int unsigned NPIN    = GROUPS * PINS,
  localparam int unsigned ADDR_W  = $clog2(GROUPS + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pins_i,
  input  logic              gie_i,
  input  logic [GROUPS-1:0] ack_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [GROUPS-1:0] irq_o
);
  logic [NPIN-1:0]             pins_s;
  logic [GROUPS-1:0][PINS-1:0] mask;
  logic [GROUPS-1:0]           enable;
  logic [GROUPS-1:0]           w1c;
  logic [GROUPS-1:0]           hit;
  logic [GROUPS-1:0]           flag;

  pci_sync #(.WIDTH(NPIN), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .din(pins_i), .dout(pins_s)
  );

  pci_regs #(.GROUPS(GROUPS), .PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flags(flag),
    .mask(mask), .enable(enable), .w1c(w1c)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    pci_edge #(.WIDTH(PINS)) u_edge (
      .clk(clk), .rst(rst), .level(pins_s[g*PINS +: PINS]),
      .mask(mask[g]), .hit(hit[g])
    );
    pci_flag u_flag (
      .clk(clk), .rst(rst), .hit(hit[g]), .clr(w1c[g] | ack_i[g]),
      .flag(flag[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= flag & enable & {GROUPS{gie_i}};
  end

  AST_GIE_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (rst)
    !gie_i |=> (irq_o == '0)); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (irq_o != '0) |-> ((irq_o & ~$past(flag)) == '0)); // R7
endmodule

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pins = '0;
  logic        gie = 1'b0;
  logic [1:0]  ack = '0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_change_irq u_dut (
    .clk(clk), .rst(rst), .pins_i(pins), .gie_i(gie), .ack_i(ack),
    .bus_addr(addr), .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(2'd0, 8'hFF);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R9 irq after reset", int'(irq), 0);
    check("R9 rdata after reset", int'(rdata), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R9 register reset value", int'(d), 0);
    end
  endtask

  task automatic t_any_edge();
    logic [7:0] d;
    wr(2'd1, 8'h08); wr(2'd2, 8'h10);
    @(negedge clk); pins[3] = 1'b1; settle();
    rd(2'd0, d); check("R2 rising edge group 0 (R1)", int'(d), 1);
    settle(); rd(2'd0, d); check("R2 flag sticky", int'(d), 1);
    clear_all();
    @(negedge clk); pins[3] = 1'b0; settle();
    rd(2'd0, d); check("R2 falling edge group 0", int'(d), 1);
    clear_all();
    @(negedge clk); pins[12] = 1'b1; settle();
    rd(2'd0, d); check("R1 pin 12 sets group 1 only", int'(d), 2);
    clear_all();
  endtask

  task automatic t_mask();
    logic [7:0] d;
    @(negedge clk); pins[5] = 1'b1; pins[8] = 1'b1; pins[15] = 1'b1; settle();
    rd(2'd0, d); check("R3 masked-off pins ignored", int'(d), 0);
    rd(2'd1, d); check("R3 mask 0 readback", int'(d), 8'h08);
    rd(2'd2, d); check("R3 mask 1 readback", int'(d), 8'h10);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    @(negedge clk); pins[3] = 1'b1; pins[12] = 1'b0; settle();
    rd(2'd0, d); check("R4 both flags set", int'(d), 3);
    wr(2'd0, 8'h02); rd(2'd0, d); check("R4 write 1 clears only bit 1", int'(d), 1);
    wr(2'd0, 8'h00); rd(2'd0, d); check("R4 write 0 keeps flag", int'(d), 1);
    wr(2'd0, 8'h01); rd(2'd0, d); check("R4 write 1 clears bit 0", int'(d), 0);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    @(negedge clk); pins[3] = 1'b0; pins[12] = 1'b1; settle();
    @(negedge clk); ack = 2'b01;
    @(negedge clk); ack = 2'b00;
    rd(2'd0, d); check("R5 ack 0 clears group 0 only", int'(d), 2);
    @(negedge clk); ack = 2'b10;
    @(negedge clk); ack = 2'b00;
    rd(2'd0, d); check("R5 ack 1 clears group 1", int'(d), 0);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    @(negedge clk); pins[3] = 1'b1;
    @(negedge clk); @(negedge clk); ack = 2'b01;
    @(negedge clk); ack = 2'b00;
    rd(2'd0, d); check("R6 change beats ack", int'(d), 1);
    @(negedge clk); pins[12] = 1'b0;
    @(negedge clk); @(negedge clk); addr = 2'd0; wdata = 8'h03; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(2'd0, d); check("R6 change beats write-one clear", int'(d), 2);
    clear_all();
  endtask

  task automatic t_irq();
    logic [7:0] d;
    @(negedge clk); pins[3] = 1'b0; settle();
    gie = 1'b1; @(negedge clk); @(negedge clk);
    check("R7 no irq with enables zero", int'(irq), 0);
    wr(2'd3, 8'h01);
    @(negedge clk); check("R7 irq when flag, enable, gie set", int'(irq), 1);
    gie = 1'b0; @(negedge clk);
    check("R7 gie low drops irq", int'(irq), 0);
    gie = 1'b1; @(negedge clk);
    check("R7 irq back with gie", int'(irq), 1);
    clear_all(); @(negedge clk);
    check("R7 irq drops after flag cleared", int'(irq), 0);
    wr(2'd3, 8'hFF); rd(2'd3, d);
    check("R8 enable upper bits read zero", int'(d), 3);
    wr(2'd0, 8'hFC); rd(2'd0, d);
    check("R8 flag upper bits read zero", int'(d), 0);
  endtask

  task automatic t_read_side_effect();
    logic [7:0] d;
    @(negedge clk); pins[3] = 1'b1; settle();
    rd(2'd0, d); rd(2'd0, d); rd(2'd0, d);
    check("R10 repeated reads keep flag", int'(d), 1);
    @(negedge clk); addr = 2'd1;
    #1 check("R10 rdata not yet updated", int'(rdata), 1);
    @(negedge clk); check("R10 rdata one cycle later", int'(rdata), 8'h08);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_any_edge();
    t_mask();
    t_w1c();
    t_ack();
    t_set_wins();
    t_irq();
    t_read_side_effect();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule